// File: doc/BRIEF.md
# Overwriting Receive Byte Buffer

This block holds received bytes between a receive decoder and a host that reads them at its own pace. The decoder pushes a byte with a write strobe. The host sees the oldest stored byte on a read port and removes it with a read strobe. An occupancy count is always visible, so the host knows how many bytes are waiting.

The buffer never refuses a byte. Once it is full, each new byte replaces the oldest one, so the host keeps the most recent data. A two-bit select picks an occupancy level. When a write makes the count climb to that level, the block raises a one-cycle interrupt pulse. Reads that move the count down through the level never raise it. A synchronous clear empties the buffer when a new reception starts.

Top module: `rx_byte_buffer`

## Requirements
- R1: After asynchronous reset, count_o is 0, irq_o is 0 and rd_data_o is 0.
- R2: Bytes come out in the order they were written. While count_o is nonzero, rd_data_o shows the oldest stored byte without delay, and a cycle with rd_en_i high removes that byte.
- R3: A write without an effective read raises count_o by one, up to a ceiling of 16. An effective read without a write lowers it by one.
- R4: A write while count_o is 16 drops the oldest byte and keeps count_o at 16. After 20 writes of 1 to 20 with no reads, the reads return 5 to 20.
- R5: While count_o is 0, rd_data_o is 0. A read strobe on an empty buffer changes nothing, and a write in that same cycle counts as a plain write.
- R6: A write and an effective read in the same cycle leave count_o unchanged and never raise irq_o.
- R7: irq_o is high for exactly the one cycle after the write that moved count_o upward to the selected level. thr_sel_i values 0, 1, 2 and 3 select levels 1, 4, 8 and 12.
- R8: A read that moves count_o down to, or through, the selected level never raises irq_o.
- R9: clear_i takes priority over any write or read in the same cycle. It leaves count_o at 0, irq_o at 0, and the next write is the first byte read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of pointers, count and interrupt |
| wr_en_i | input | 1 | Write strobe from the decoder |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Read strobe from the host; removes the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte, 0 when empty |
| count_o | output | 5 | Number of stored bytes, 0 to 16 |
| thr_sel_i | input | 2 | Interrupt level select: 1, 4, 8 or 12 bytes |
| irq_o | output | 1 | One-cycle pulse on an upward count reaching the level |

## Verification
The decoder's write and the host's read can fall in the same cycle. This case is provoked in three states. On an empty buffer the read must be ignored, so the count rises and the level-1 interrupt may fire. On a partly filled buffer the count must hold and no pulse may appear, even when the write alone would have reached the level. On a full buffer the oldest byte leaves once and the new byte lands at the tail. Each case is judged at the ports, from count_o and irq_o in the following cycle and from the byte order read back afterwards.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 2;

  // interrupt level for each select code
  function automatic int unsigned thr_level(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    thr_level = 1;
      2'd1:    thr_level = 4;
      2'd2:    thr_level = 8;
      default: thr_level = 12;
    endcase
  endfunction
endpackage

// File: rtl/rxbuf_ptr.sv
module rxbuf_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rxbuf_mem.sv
module rxbuf_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxbuf_occ.sv
module rxbuf_occ
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic             rd_req_i,
  input  logic [SEL_W-1:0] thr_sel_i,
  output logic [CW-1:0]    count_o,
  output logic             rd_eff_o,
  output logic             full_o,
  output logic             irq_o
);
  logic [CW-1:0] count_q, count_d;
  logic          irq_q, irq_d;
  logic          up;

  assign full_o   = (count_q == CW'(DEPTH));
  assign rd_eff_o = rd_req_i && (count_q != '0);
  assign up       = wr_i && !rd_eff_o && !full_o;

  always_comb begin
    count_d = count_q;
    if (clear_i)                    count_d = '0;
    else if (up)                    count_d = count_q + 1'b1;
    else if (rd_eff_o && !wr_i)     count_d = count_q - 1'b1;
    irq_d = !clear_i && up && (count_q + 1'b1 == CW'(thr_level(thr_sel_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      irq_q   <= irq_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CW-1:0]     count_o,
  input  logic [SEL_W-1:0]  thr_sel_i,
  output logic              irq_o
);
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [DATA_W-1:0] head;
  logic              rd_eff, full, wr_adv, rd_adv;

  rxbuf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .wr_i      (wr_en_i),
    .rd_req_i  (rd_en_i),
    .thr_sel_i (thr_sel_i),
    .count_o   (count_o),
    .rd_eff_o  (rd_eff),
    .full_o    (full),
    .irq_o     (irq_o)
  );

  assign wr_adv = !clear_i && wr_en_i;
  // full buffer: a write drops the oldest byte, so the head moves too
  assign rd_adv = !clear_i && (rd_eff || (wr_en_i && full));

  rxbuf_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (clear_i),
    .adv_i (wr_adv), .ptr_o (wr_ptr)
  );

  rxbuf_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clear_i (clear_i),
    .adv_i (rd_adv), .ptr_o (rd_ptr)
  );

  rxbuf_mem #(.DEPTH(DEPTH), .DW(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_adv),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (head)
  );

  assign rd_data_o = (count_o == '0) ? '0 : head;
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CW-1:0]     count_o,
  input logic              irq_o
);
  assert_count_ceiling_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  assert_empty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_data_o == '0));

  assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && !irq_o));

  assert_same_cycle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wr_en_i && rd_en_i && count_o != '0) |=> ($stable(count_o) && !irq_o));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && wr_en_i && count_o == CW'(DEPTH)) |=> (count_o == CW'(DEPTH)));

  assert_irq_upward_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i) |=> !irq_o);

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind rx_byte_buffer rxbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clear_i   (clear_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .count_o   (count_o),
  .irq_o     (irq_o)
);

// File: tb/tb_rx_byte_buffer.sv
module tb_rx_byte_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] sel = '0;
  logic [7:0] rdata;
  logic [4:0] count;
  logic       irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_buffer dut (
    .clk_i (clk), .rst_ni (rst_n), .clear_i (clear),
    .wr_en_i (wr), .wr_data_i (wdata), .rd_en_i (rd),
    .rd_data_o (rdata), .count_o (count), .thr_sel_i (sel), .irq_o (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with given strobes; returns irq seen after the edge
  task automatic step(input bit w, input logic [7:0] d, input bit r, input bit c, output bit irq_seen);
    wr = w; wdata = d; rd = r; clear = c;
    @(posedge clk); #1;
    wr = 0; rd = 0; clear = 0;
    irq_seen = irq;
  endtask

  task automatic push(input logic [7:0] d);
    bit i; step(1, d, 0, 0, i);
  endtask

  task automatic pop_expect(input logic [7:0] d, input string req);
    bit i;
    check(rdata == d, req, rdata, d);
    step(0, 0, 1, 0, i);
  endtask

  task automatic do_clear();
    bit i; step(0, 0, 0, 1, i);
  endtask

  task automatic t_reset();
    check(count == 0, "R1 count", count, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(rdata == 0, "R1 rdata", rdata, 0);
  endtask

  task automatic t_order();
    do_clear();
    for (int k = 0; k < 5; k++) push(8'hA0 + 8'(k));
    check(count == 5, "R3 count up", count, 5);
    for (int k = 0; k < 5; k++) begin
      pop_expect(8'hA0 + 8'(k), "R2 order");
      check(count == 5'(4 - k), "R3 count down", count, 4 - k);
    end
  endtask

  task automatic t_empty();
    bit i;
    do_clear();
    check(rdata == 0, "R5 empty data", rdata, 0);
    step(0, 0, 1, 0, i);
    check(count == 0, "R5 empty read count", count, 0);
    sel = 2'd0;
    step(1, 8'h5C, 1, 0, i);  // read ignored, write counts
    check(count == 1, "R5 write with empty read", count, 1);
    check(i == 1, "R7 level 1 irq", i, 1);
    pop_expect(8'h5C, "R5 byte kept");
  endtask

  task automatic t_overflow();
    do_clear();
    for (int k = 1; k <= 20; k++) push(8'(k));
    check(count == 16, "R4 count held", count, 16);
    for (int k = 5; k <= 20; k++) pop_expect(8'(k), "R4 oldest dropped");
    check(count == 0, "R4 drained", count, 0);
  endtask

  task automatic t_simul();
    bit i;
    do_clear();
    sel = 2'd1;
    for (int k = 0; k < 3; k++) push(8'(16 + k));
    step(1, 8'd19, 1, 0, i);  // would reach 4 alone
    check(count == 3, "R6 count held", count, 3);
    check(i == 0, "R6 no irq", i, 0);
    pop_expect(8'd17, "R6 order");
    pop_expect(8'd18, "R6 order");
    pop_expect(8'd19, "R6 order");
    do_clear();
    for (int k = 0; k < 16; k++) push(8'(k));
    step(1, 8'hEE, 1, 0, i);
    check(count == 16, "R6 full count", count, 16);
    for (int k = 1; k < 16; k++) pop_expect(8'(k), "R6 full order");
    pop_expect(8'hEE, "R6 full tail");
  endtask

  task automatic t_levels();
    int lv[4] = '{1, 4, 8, 12};
    for (int s = 0; s < 4; s++) begin
      int pulses = 0;
      bit i;
      do_clear();
      sel = 2'(s);
      for (int k = 1; k <= 14; k++) begin
        step(1, 8'(k), 0, 0, i);
        if (i) begin
          pulses++;
          check(k == lv[s], "R7 pulse position", k, lv[s]);
        end
      end
      check(pulses == 1, "R7 single pulse", pulses, 1);
    end
  endtask

  task automatic t_down();
    int pulses = 0;
    bit i;
    do_clear();
    sel = 2'd1;
    for (int k = 0; k < 6; k++) push(8'(k));
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 1, 0, i);
      if (i) pulses++;
    end
    check(pulses == 0, "R8 no irq on reads", pulses, 0);
  endtask

  task automatic t_clear();
    bit i;
    do_clear();
    sel = 2'd0;
    push(8'h11); push(8'h22);
    step(1, 8'h33, 1, 1, i);
    check(count == 0, "R9 clear count", count, 0);
    check(i == 0, "R9 clear irq", i, 0);
    push(8'h44);
    pop_expect(8'h44, "R9 first after clear");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_order();
    t_empty();
    t_overflow();
    t_simul();
    t_levels();
    t_down();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule